// File: doc/BRIEF.md
# Write-Once Coherence State Controller

This block keeps the coherence state of every line of one private cache that sits on a shared snooping bus. Each line has one of four states: invalid, clean-shared, exclusive-clean and modified. The block steps these states as the local processor and the other caches issue requests. On the processor side it takes read, write and replace requests together with a line index and a tag-match flag. It reports hit or miss and raises the bus command that the request needs. On the snoop side it watches transactions that other caches put on the bus. It updates its own lines, and when it holds the only modified copy it signals that it supplies the data.

The feature that sets this protocol apart is the first write to a clean-shared line. That write goes through to memory as one word, and the line becomes exclusive-clean. Later writes stay inside the cache and mark the line modified, so two writes in a row cost only one bus write. The data arrays, tag comparison, bus arbitration and memory are outside the block. Data transfers appear only as grant, done and acknowledge strobes.

Top module: `wonce_coh_ctrl`

## Requirements
- R1: Line states are coded Invalid=00, Valid=01, Reserved=10, Dirty=11. After reset every line is Invalid, so a request with the tag-match flag set still reports a miss, and `cpu_done`, `bus_req`, `snp_supply` and `wb_req` are low.
- R2: A read whose tag matches a non-Invalid line finishes locally. It raises no bus request, reports `cpu_miss`=0 and leaves the state unchanged. Processor op codes: read=0, write=1, replace=2.
- R3: A read miss requests bus command 0 (read) for the line. When it completes, the line is Valid.
- R4: A write that hits a Reserved or Dirty line raises no bus request, and the line becomes Dirty.
- R5: A write that hits a Valid line requests bus command 2 (one-word write-through). When it completes, the line is Reserved.
- R6: A write miss requests bus command 1 (read-for-ownership). When it completes, the line is Dirty.
- R7: Replacing a Dirty line requests bus command 3 (write-back) and leaves the line Invalid. Replacing any other line raises no bus request and leaves it Invalid.
- R8: A matching snooped read (snoop command 0) turns a Reserved line into Valid and leaves a Valid line alone. On a Dirty line it pulses `snp_supply` for one cycle and raises `wb_req` with the line's index. `wb_req` holds until `wb_ack`, and then the line becomes Valid.
- R9: A matching snooped write-through (2) or read-for-ownership (1) makes a Valid, Reserved or Dirty line Invalid. A read-for-ownership that finds the line Dirty also pulses `snp_supply` for one cycle.
- R10: A snooped write-back (3), a snoop with `snp_match` low, or a snoop to an Invalid line changes no state and does not supply data.
- R11: Only one processor request is in progress at a time. It is not accepted in a cycle with `snp_valid` high or with `wb_req` pending. A bus request completes only in a cycle where `bus_gnt` and `bus_done` are both high. `cpu_done` pulses for one cycle after completion, and `bus_idx` stays stable while `bus_req` is held.
- R12: If, before its grant, a pending write-through finds its line invalidated by a snoop, the request becomes a read-for-ownership and the line ends Dirty. If a pending write-back finds its line no longer Dirty, the request is dropped without a bus cycle and completes with the line Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_op | input | 2 | 0 read, 1 write, 2 replace |
| cpu_idx | input | IDX_W | Line index of the request |
| cpu_hit | input | 1 | Tag match for the requested line |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_miss | output | 1 | Request missed; valid with `cpu_done` |
| bus_req | output | 1 | Bus command pending |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 write-through, 3 write-back |
| bus_idx | output | IDX_W | Line of the bus command |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Data transfer of the granted command finished |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_idx | input | IDX_W | Line index of the snooped transaction |
| snp_match | input | 1 | Snooped tag matches the local line |
| snp_supply | output | 1 | One-cycle pulse: this cache supplies the modified line |
| wb_req | output | 1 | Write-back forced by a snooped read, pending |
| wb_idx | output | IDX_W | Line of that write-back |
| wb_ack | input | 1 | Forced write-back finished |

## Verification
Every result of a request that the block handles locally is due one cycle after acceptance: `cpu_done` and `cpu_miss` rise in the cycle after the edge that samples the request. A bus request is visible in that same cycle. Its `cpu_done` follows one cycle after the edge where grant and done are seen together. A snoop shows `snp_supply` and `wb_req` one cycle after its sampling edge, and the line turns Valid on the `wb_ack` edge. The bench drives on the falling edge and checks at the next falling edge after the register that produces each result. A reference model of line states in the bench predicts the command, the miss flag and the supply flag for each of the random and directed operations.

// File: rtl/wo_pkg.sv
package wo_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_V = 2'b01,
    ST_R = 2'b10,
    ST_D = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_RPL = 2'd2,
    OP_RSV = 2'd3
  } cpu_op_e;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RFO = 2'd1,
    BC_WT  = 2'd2,
    BC_WB  = 2'd3
  } bus_cmd_e;

endpackage

// File: rtl/wo_line_states.sv
module wo_line_states
  import wo_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cpu_ridx,
  output line_st_e         cpu_rst,
  input  logic [IDX_W-1:0] snp_ridx,
  output line_st_e         snp_rst,
  input  logic             cpu_we,
  input  logic [IDX_W-1:0] cpu_widx,
  input  line_st_e         cpu_wst,
  input  logic             snp_we,
  input  logic [IDX_W-1:0] snp_widx,
  input  line_st_e         snp_wst
);

  line_st_e st_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic     hit_snp, hit_cpu;
    line_st_e st_d;
    always_comb begin
      hit_snp = snp_we && (snp_widx == IDX_W'(g));
      hit_cpu = cpu_we && (cpu_widx == IDX_W'(g));
      st_d    = st_q[g];
      if (hit_snp)      st_d = snp_wst;
      else if (hit_cpu) st_d = cpu_wst;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  st_q[g] <= ST_I;
      else if (hit_snp || hit_cpu) st_q[g] <= st_d;
    end
  end

  assign cpu_rst = st_q[cpu_ridx];
  assign snp_rst = st_q[snp_ridx];

  // R11
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && snp_we && (cpu_widx == snp_widx)));

endmodule

// File: rtl/wo_cpu_unit.sv
module wo_cpu_unit
  import wo_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic [1:0]       cpu_op,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             cpu_hit,
  input  logic             snp_busy,
  output logic             cpu_done,
  output logic             cpu_miss,
  output logic             bus_req,
  output logic [1:0]       bus_cmd,
  output logic [IDX_W-1:0] bus_idx,
  input  logic             bus_gnt,
  input  logic             bus_done,
  output logic [IDX_W-1:0] rd_idx,
  input  line_st_e         line_st,
  output logic             we,
  output logic [IDX_W-1:0] widx,
  output line_st_e         wst
);

  typedef enum logic [1:0] {C_IDLE, C_BUS, C_DONE} cfsm_e;

  cfsm_e            fsm_q, fsm_d;
  bus_cmd_e         cmd_q, cmd_d, eff_cmd;
  logic [IDX_W-1:0] idx_q;
  logic             miss_q, miss_d;
  logic             accept, eff_hit, abort_wb, wt_lost;

  always_comb begin
    rd_idx   = (fsm_q == C_IDLE) ? cpu_idx : idx_q;
    eff_hit  = cpu_hit && (line_st != ST_I);
    accept   = (fsm_q == C_IDLE) && cpu_req && !snp_busy;
    abort_wb = (fsm_q == C_BUS) && (cmd_q == BC_WB) && (line_st != ST_D);
    wt_lost  = (fsm_q == C_BUS) && (cmd_q == BC_WT) && (line_st == ST_I);
    eff_cmd  = wt_lost ? BC_RFO : cmd_q;

    fsm_d  = fsm_q;
    cmd_d  = cmd_q;
    miss_d = miss_q;
    we     = 1'b0;
    widx   = rd_idx;
    wst    = line_st;

    unique case (fsm_q)
      C_IDLE: begin
        if (accept) begin
          miss_d = !eff_hit;
          fsm_d  = C_DONE;
          unique case (cpu_op_e'(cpu_op))
            OP_WR: begin
              if (!eff_hit) begin
                fsm_d = C_BUS;
                cmd_d = BC_RFO;
              end else if (line_st == ST_V) begin
                fsm_d = C_BUS;
                cmd_d = BC_WT;
              end else begin
                we  = 1'b1;
                wst = ST_D;
              end
            end
            OP_RPL: begin
              if (line_st == ST_D) begin
                fsm_d = C_BUS;
                cmd_d = BC_WB;
              end else begin
                we  = (line_st != ST_I);
                wst = ST_I;
              end
            end
            default: begin
              if (!eff_hit) begin
                fsm_d = C_BUS;
                cmd_d = BC_RD;
              end
            end
          endcase
        end
      end
      C_BUS: begin
        cmd_d = eff_cmd;
        if (abort_wb) begin
          we    = 1'b1;
          wst   = ST_I;
          fsm_d = C_DONE;
        end else if (bus_gnt && bus_done) begin
          we    = 1'b1;
          fsm_d = C_DONE;
          unique case (eff_cmd)
            BC_RD:  wst = ST_V;
            BC_RFO: wst = ST_D;
            BC_WT:  wst = ST_R;
            BC_WB:  wst = ST_I;
          endcase
        end
      end
      default: fsm_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= C_IDLE;
      cmd_q  <= BC_RD;
      idx_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      fsm_q <= fsm_d;
      cmd_q <= cmd_d;
      if (accept) begin
        idx_q  <= cpu_idx;
        miss_q <= miss_d;
      end
    end
  end

  assign cpu_done = (fsm_q == C_DONE);
  assign cpu_miss = miss_q;
  assign bus_req  = (fsm_q == C_BUS) && !abort_wb;
  assign bus_cmd  = eff_cmd;
  assign bus_idx  = idx_q;

  // R4
  local_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cpu_op == 2'd1) && eff_hit && line_st[1]) |=> (!bus_req && cpu_done));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  // R11
  bus_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> (bus_idx == $past(bus_idx)));

  // R11
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(bus_gnt && bus_done)) |=> !cpu_done);

endmodule

// File: rtl/wo_snoop_unit.sv
module wo_snoop_unit
  import wo_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             snp_match,
  input  line_st_e         line_st,
  output logic             snp_supply,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_idx,
  input  logic             wb_ack,
  output logic             busy,
  output logic             we,
  output logic [IDX_W-1:0] widx,
  output line_st_e         wst
);

  logic             supply_q, supply_d;
  logic             pend_q, pend_d;
  logic [IDX_W-1:0] pidx_q;
  logic             take;

  always_comb begin
    take     = snp_valid && snp_match && (line_st != ST_I) && !pend_q;
    supply_d = 1'b0;
    pend_d   = pend_q;
    we       = 1'b0;
    widx     = snp_idx;
    wst      = line_st;

    if (pend_q && wb_ack) begin
      pend_d = 1'b0;
      we     = 1'b1;
      widx   = pidx_q;
      wst    = ST_V;
    end else if (take) begin
      unique case (bus_cmd_e'(snp_cmd))
        BC_RD: begin
          if (line_st == ST_D) begin
            supply_d = 1'b1;
            pend_d   = 1'b1;
          end else if (line_st == ST_R) begin
            we  = 1'b1;
            wst = ST_V;
          end
        end
        BC_RFO: begin
          supply_d = (line_st == ST_D);
          we       = 1'b1;
          wst      = ST_I;
        end
        BC_WT: begin
          we  = 1'b1;
          wst = ST_I;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supply_q <= 1'b0;
      pend_q   <= 1'b0;
      pidx_q   <= '0;
    end else begin
      supply_q <= supply_d;
      pend_q   <= pend_d;
      if (take && supply_d) pidx_q <= snp_idx;
    end
  end

  assign snp_supply = supply_q;
  assign wb_req     = pend_q;
  assign wb_idx     = pidx_q;
  assign busy       = snp_valid || pend_q;

  // R8
  supply_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |=> !snp_supply);

  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_idx)));

  // R8
  wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_ack) |=> !wb_req);

endmodule

// File: rtl/wonce_coh_ctrl.sv
module wonce_coh_ctrl
  import wo_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cpu_req,
  input  logic [1:0]       cpu_op,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             cpu_hit,
  output logic             cpu_done,
  output logic             cpu_miss,
  output logic             bus_req,
  output logic [1:0]       bus_cmd,
  output logic [IDX_W-1:0] bus_idx,
  input  logic             bus_gnt,
  input  logic             bus_done,
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             snp_match,
  output logic             snp_supply,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_idx,
  input  logic             wb_ack
);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [IDX_W-1:0] cpu_ridx, cpu_widx, snp_widx;
  line_st_e         cpu_rst, snp_rst, cpu_wst, snp_wst;
  logic             cpu_we, snp_we, snp_busy;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  wo_line_states #(.LINES(LINES), .IDX_W(IDX_W)) u_states (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ridx (cpu_ridx),
    .cpu_rst  (cpu_rst),
    .snp_ridx (snp_idx),
    .snp_rst  (snp_rst),
    .cpu_we   (cpu_we),
    .cpu_widx (cpu_widx),
    .cpu_wst  (cpu_wst),
    .snp_we   (snp_we),
    .snp_widx (snp_widx),
    .snp_wst  (snp_wst)
  );

  wo_cpu_unit #(.IDX_W(IDX_W)) u_cpu (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_op   (cpu_op),
    .cpu_idx  (cpu_idx),
    .cpu_hit  (cpu_hit),
    .snp_busy (snp_busy),
    .cpu_done (cpu_done),
    .cpu_miss (cpu_miss),
    .bus_req  (bus_req),
    .bus_cmd  (bus_cmd),
    .bus_idx  (bus_idx),
    .bus_gnt  (bus_gnt),
    .bus_done (bus_done),
    .rd_idx   (cpu_ridx),
    .line_st  (cpu_rst),
    .we       (cpu_we),
    .widx     (cpu_widx),
    .wst      (cpu_wst)
  );

  wo_snoop_unit #(.IDX_W(IDX_W)) u_snp (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .snp_idx    (snp_idx),
    .snp_match  (snp_match),
    .line_st    (snp_rst),
    .snp_supply (snp_supply),
    .wb_req     (wb_req),
    .wb_idx     (wb_idx),
    .wb_ack     (wb_ack),
    .busy       (snp_busy),
    .we         (snp_we),
    .widx       (snp_widx),
    .wst        (snp_wst)
  );

  // R11
  single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && wb_req && (bus_cmd == 2'd3) && (bus_idx == wb_idx)));

endmodule

// File: tb/wonce_coh_ctrl_tb.sv
module wonce_coh_ctrl_tb;

  localparam int LINES = 16;
  localparam int IDX_W = 4;
  localparam time TCLK = 10ns;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cpu_req = 1'b0, cpu_hit = 1'b0;
  logic [1:0]       cpu_op = 2'd0;
  logic [IDX_W-1:0] cpu_idx = '0;
  logic             cpu_done, cpu_miss, bus_req;
  logic [1:0]       bus_cmd;
  logic [IDX_W-1:0] bus_idx;
  logic             bus_gnt = 1'b0, bus_done = 1'b0;
  logic             snp_valid = 1'b0, snp_match = 1'b0;
  logic [1:0]       snp_cmd = 2'd0;
  logic [IDX_W-1:0] snp_idx = '0;
  logic             snp_supply, wb_req;
  logic [IDX_W-1:0] wb_idx;
  logic             wb_ack = 1'b0;

  int n_vec = 0;
  int n_bad = 0;
  logic [1:0] model [LINES];

  always #(TCLK/2) clk = ~clk;

  wonce_coh_ctrl #(.LINES(LINES), .IDX_W(IDX_W)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // bus command needed: {need, cmd}
  function automatic logic [2:0] f_cmd(input logic [1:0] op, input logic hit, input logic [1:0] st);
    logic h = hit && (st != 2'd0);
    case (op)
      2'd1:    return !h ? 3'b101 : (st == 2'd1) ? 3'b110 : 3'b000;
      2'd2:    return (st == 2'd3) ? 3'b111 : 3'b000;
      default: return !h ? 3'b100 : 3'b000;
    endcase
  endfunction

  function automatic logic [1:0] f_next(input logic [1:0] op, input logic hit, input logic [1:0] st);
    logic h = hit && (st != 2'd0);
    case (op)
      2'd1:    return !h ? 2'd3 : (st == 2'd1) ? 2'd2 : 2'd3;
      2'd2:    return 2'd0;
      default: return !h ? 2'd1 : st;
    endcase
  endfunction

  function automatic string f_tag(input logic [1:0] op, input logic hit, input logic [1:0] st);
    logic h = hit && (st != 2'd0);
    case (op)
      2'd1:    return !h ? "R6" : (st == 2'd1) ? "R5" : "R4";
      2'd2:    return "R7";
      default: return h ? "R2" : "R3";
    endcase
  endfunction

  task automatic do_cpu(input logic [1:0] op, input int idx, input logic hit, input int gdly);
    logic [1:0] st = model[idx];
    logic [2:0] ec = f_cmd(op, hit, st);
    string tg = f_tag(op, hit, st);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = op; cpu_idx = IDX_W'(idx); cpu_hit = hit;
    @(negedge clk);
    chk({tg, " bus_req"}, bus_req, ec[2]);
    if (ec[2]) begin
      chk({tg, " bus_cmd"}, bus_cmd, ec[1:0]);
      chk({tg, " bus_idx"}, bus_idx, idx);
      for (int k = 0; k < gdly; k++) begin
        bus_gnt = 1'b1;
        @(negedge clk);
        chk("R11 no done before bus_done", cpu_done, 0);
      end
      bus_gnt = 1'b1; bus_done = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0; bus_done = 1'b0;
    end
    chk({tg, " done"}, cpu_done, 1);
    chk({tg, " miss"}, cpu_miss, !(hit && st != 2'd0));
    cpu_req = 1'b0;
    model[idx] = f_next(op, hit, st);
    @(negedge clk);
    chk("R11 done pulse", cpu_done, 0);
  endtask

  task automatic do_snp(input logic [1:0] cmd, input int idx, input logic match, input int adly);
    logic [1:0] st = model[idx];
    logic act = match && (st != 2'd0);
    logic sup = act && (st == 2'd3) && (cmd == 2'd0 || cmd == 2'd1);
    logic wb = sup && (cmd == 2'd0);
    string tg = !act || cmd == 2'd3 ? "R10" : (cmd == 2'd0) ? "R8" : "R9";
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_idx = IDX_W'(idx); snp_match = match;
    @(negedge clk);
    snp_valid = 1'b0;
    chk({tg, " supply"}, snp_supply, sup);
    chk({tg, " wb_req"}, wb_req, wb);
    if (wb) begin
      chk({tg, " wb_idx"}, wb_idx, idx);
      for (int k = 0; k < adly; k++) begin
        @(negedge clk);
        chk({tg, " wb_req held"}, wb_req, 1);
      end
      wb_ack = 1'b1;
      @(negedge clk);
      wb_ack = 1'b0;
      chk({tg, " wb_req released"}, wb_req, 0);
    end else begin
      @(negedge clk);
    end
    chk({tg, " supply pulse"}, snp_supply, 0);
    if (act) begin
      case (cmd)
        2'd0:    model[idx] = (st == 2'd2 || st == 2'd3) ? 2'd1 : st;
        2'd1, 2'd2: model[idx] = 2'd0;
        default: ;
      endcase
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    for (int i = 0; i < LINES; i++) model[i] = 2'd0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 cpu_done", cpu_done, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 snp_supply", snp_supply, 0);
    chk("R1 wb_req", wb_req, 0);
    for (int i = 0; i < LINES; i++) do_cpu(2'd0, i, 1'b1, 0);
    for (int i = 0; i < LINES; i++) do_cpu(2'd2, i, 1'b1, 0);

    // directed: write-once sequence on line 1
    do_cpu(2'd0, 1, 1'b0, 0);   // R3 -> V
    do_cpu(2'd0, 1, 1'b1, 0);   // R2
    do_cpu(2'd1, 1, 1'b1, 2);   // R5 -> R
    do_cpu(2'd1, 1, 1'b1, 0);   // R4 -> D
    do_snp(2'd0, 1, 1'b1, 3);   // R8 supply, -> V
    do_cpu(2'd1, 1, 1'b1, 0);   // R5 again
    do_snp(2'd0, 1, 1'b1, 0);   // R8 R -> V
    do_snp(2'd2, 1, 1'b1, 0);   // R9 -> I
    do_cpu(2'd1, 1, 1'b1, 1);   // R6 -> D
    do_snp(2'd3, 1, 1'b1, 0);   // R10 no effect
    do_snp(2'd1, 1, 1'b0, 0);   // R10 no match
    do_cpu(2'd2, 1, 1'b1, 0);   // R7 write-back

    // R11: request not accepted while snp_valid is high
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = 2'd0; cpu_idx = 4'd5; cpu_hit = 1'b0;
    snp_valid = 1'b1; snp_cmd = 2'd3; snp_idx = 4'd5; snp_match = 1'b1;
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R11 held off by snoop", bus_req, 0);
    @(negedge clk);
    chk("R11 accepted after snoop", bus_req, 1);
    bus_gnt = 1'b1; bus_done = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0; bus_done = 1'b0;
    chk("R11 done", cpu_done, 1);
    cpu_req = 1'b0;
    model[5] = 2'd1;
    @(negedge clk);

    // R12: pending write-through loses its line, becomes read-for-ownership
    do_cpu(2'd0, 2, 1'b0, 0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = 2'd1; cpu_idx = 4'd2; cpu_hit = 1'b1;
    @(negedge clk);
    chk("R5 pending write-through", bus_cmd, 2);
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_idx = 4'd2; snp_match = 1'b1;
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R12 converted command", bus_cmd, 1);
    chk("R12 still requesting", bus_req, 1);
    bus_gnt = 1'b1; bus_done = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0; bus_done = 1'b0;
    chk("R12 done", cpu_done, 1);
    cpu_req = 1'b0;
    model[2] = 2'd3;
    do_snp(2'd0, 2, 1'b1, 0);   // R12 line ended Dirty -> supply

    // R12: pending write-back withdrawn after snoop takes the line
    do_cpu(2'd1, 3, 1'b0, 0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_op = 2'd2; cpu_idx = 4'd3; cpu_hit = 1'b1;
    @(negedge clk);
    chk("R7 pending write-back", bus_cmd, 3);
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_idx = 4'd3; snp_match = 1'b1;
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R9 supply on ownership read", snp_supply, 1);
    chk("R12 write-back withdrawn", bus_req, 0);
    @(negedge clk);
    chk("R12 done without bus", cpu_done, 1);
    cpu_req = 1'b0;
    model[3] = 2'd0;
    do_cpu(2'd0, 3, 1'b1, 0);   // R12 line ended Invalid -> miss

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int idx = $urandom_range(0, 3);
      if ($urandom_range(0, 2) != 0)
        do_cpu(2'($urandom_range(0, 2)), idx, ($urandom_range(0, 3) != 0), $urandom_range(0, 2));
      else
        do_snp(2'($urandom_range(0, 3)), idx, ($urandom_range(0, 3) != 0), $urandom_range(0, 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule